// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two contact signals of a mechanical or optical rotary encoder into a running shaft position. The two raw inputs, `enc_b` and `enc_a`, follow a 2-bit Gray code. Each edge of either contact moves the pair one step around the cycle 00, 01, 11, 10. The block first passes both inputs through a synchroniser. It then holds the previous synchronised pair in a four-state register and compares that pair with the current one to find the direction of each step.

The result is a one-cycle clockwise or anticlockwise strobe. The strobe is registered once in the decoder and then registered again before it reaches the outputs and the counter, so the decoder works as a registered Mealy machine. The strobes step an up/down counter whose value is the position output. Active-low copies of both strobes, idle high, are also provided so that a counter or other logic that expects a low-going strobe can use them.

With the default parameters, a pair sampled at clock edge n produces a strobe that is visible after edge n+2. The position changes after edge n+3.

Top module: `qenc_position`

## Requirements
- R1: A clockwise step (00→01, 01→11, 11→10 or 10→00, written as the pair `{enc_b,enc_a}`) raises `step_cw` for one cycle. The position then rises by one on the following clock edge.
- R2: An anticlockwise step (00→10, 10→11, 11→01 or 01→00) raises `step_ccw` for one cycle. The position then falls by one on the following clock edge.
- R3: `step_cw` and `step_ccw` are never high in the same cycle. Each pulse lasts one cycle for each input change, including when the input changes on every clock.
- R4: If a new pair is sampled at clock edge n, its strobe is high in the cycle after edge n+2. The position reflects the step after edge n+3.
- R5: A change of both bits at once, such as 00→11 or 01→10, produces neither strobe and leaves the position unchanged.
- R6: While `{enc_b,enc_a}` holds steady, neither strobe is raised and the position holds.
- R7: The position is CNT_W bits wide (default 4, range 0 to 15). It wraps in both directions: 15+1 gives 0 and 0−1 gives 15.
- R8: `step_cw_n` and `step_ccw_n` are the inverses of `step_cw` and `step_ccw`. They idle high and go low for exactly the strobe cycle.
- R9: While `rst` is high at a clock edge, the synchroniser, the state, the strobe registers and the position all clear to zero. After that edge, both strobes are low and the position is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_a | input | 1 | Raw encoder contact A (low bit of the pair) |
| enc_b | input | 1 | Raw encoder contact B (high bit of the pair) |
| step_cw | output | 1 | One-cycle clockwise strobe |
| step_ccw | output | 1 | One-cycle anticlockwise strobe |
| step_cw_n | output | 1 | Active-low clockwise strobe |
| step_ccw_n | output | 1 | Active-low anticlockwise strobe |
| position | output | CNT_W | Shaft position count |

## Verification
The first pattern is a slow clockwise run and then a slow anticlockwise run, each long enough to cross the wrap point. These runs separate increment from decrement and confirm the modulo-16 wrap in both directions. The second pattern is rotation with one step per clock and reversals between steps. It exposes pulses that merge, drop out or arrive at the wrong latency. The third pattern uses double-bit jumps and long holds, which should produce no strobe at all. This pattern shows whether an illegal change or a steady input is wrongly counted as a step. A reset in the middle of a run checks that every stage of the pipeline clears.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

   typedef enum logic [1:0] {
      PH_00 = 2'b00,
      PH_01 = 2'b01,
      PH_11 = 2'b11,
      PH_10 = 2'b10
   } phase_t;

   typedef struct packed {
      logic cw;
      logic ccw;
   } step_t;

   // Direction of one move from prev to cur; double-bit jumps and holds give none.
   function automatic step_t classify(input phase_t prev, input phase_t cur);
      step_t s;
      s = '0;
      unique case (prev)
         PH_00: begin s.cw = (cur == PH_01); s.ccw = (cur == PH_10); end
         PH_01: begin s.cw = (cur == PH_11); s.ccw = (cur == PH_00); end
         PH_11: begin s.cw = (cur == PH_10); s.ccw = (cur == PH_01); end
         PH_10: begin s.cw = (cur == PH_00); s.ccw = (cur == PH_11); end
         default: s = '0;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
   parameter int STAGES = 1,
   parameter int WIDTH  = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   localparam int LAST = STAGES - 1;

   logic [WIDTH-1:0] chain [STAGES];

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) chain[0] <= '0;
               else     chain[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) chain[i] <= '0;
               else     chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign dout = chain[LAST];
endmodule

// File: rtl/qenc_dir.sv
module qenc_dir
   import qenc_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic [1:0] cur_ba,
   output step_t      step_q
);
   phase_t state_q;
   step_t  step_d;
   step_t  step_r1;

   assign step_d = classify(state_q, phase_t'(cur_ba));

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= PH_00;
         step_r1 <= '0;
         step_q  <= '0;
      end else begin
         state_q <= phase_t'(cur_ba);
         step_r1 <= step_d;
         step_q  <= step_r1;
      end
   end
endmodule

// File: rtl/qenc_count.sv
module qenc_count #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             up,
   input  logic             down,
   output logic [WIDTH-1:0] value
);
   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   always_ff @(posedge clk) begin
      if (rst)                value <= '0;
      else if (up && !down)   value <= value + ONE;
      else if (down && !up)   value <= value - ONE;
   end
endmodule

// File: rtl/qenc_position.sv
module qenc_position
   import qenc_pkg::*;
#(
   parameter int CNT_W         = 4,
   parameter int SYNC_STAGES   = 1,
   parameter bit ACTIVE_LOW_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             enc_a,
   input  logic             enc_b,
   output logic             step_cw,
   output logic             step_ccw,
   output logic             step_cw_n,
   output logic             step_ccw_n,
   output logic [CNT_W-1:0] position
);
   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("qenc_position: CNT_W must be at least 2");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("qenc_position: SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic [1:0] sync_ba;
   step_t      step;

   qenc_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .din  ({enc_b, enc_a}),
      .dout (sync_ba)
   );

   qenc_dir u_dir (
      .clk    (clk),
      .rst    (rst),
      .cur_ba (sync_ba),
      .step_q (step)
   );

   qenc_count #(.WIDTH(CNT_W)) u_count (
      .clk   (clk),
      .rst   (rst),
      .up    (step.cw),
      .down  (step.ccw),
      .value (position)
   );

   assign step_cw  = step.cw;
   assign step_ccw = step.ccw;

   generate
      if (ACTIVE_LOW_EN) begin : g_low
         assign step_cw_n  = ~step.cw;
         assign step_ccw_n = ~step.ccw;
      end else begin : g_no_low
         assign step_cw_n  = 1'b1;
         assign step_ccw_n = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/qenc_position_chk.sv
module qenc_position_chk #(
   parameter int CNT_W         = 4,
   parameter bit ACTIVE_LOW_EN = 1'b1
) (
   input logic             clk,
   input logic             rst,
   input logic             step_cw,
   input logic             step_ccw,
   input logic             step_cw_n,
   input logic             step_ccw_n,
   input logic [CNT_W-1:0] position
);
   assert_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
      !(step_cw && step_ccw));

   assert_cw_inc_R1: assert property (@(posedge clk) disable iff (rst)
      step_cw |=> position == ($past(position) + 1'b1));

   assert_ccw_dec_R2: assert property (@(posedge clk) disable iff (rst)
      step_ccw |=> position == ($past(position) - 1'b1));

   assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
      (!step_cw && !step_ccw) |=> $stable(position));

   assert_reset_clear_R9: assert property (@(posedge clk)
      rst |=> (position == '0) && !step_cw && !step_ccw);

   generate
      if (ACTIVE_LOW_EN) begin : g_low_chk
         assert_low_pair_R8: assert property (@(posedge clk) disable iff (rst)
            (step_cw_n != step_cw) && (step_ccw_n != step_ccw));
      end
   endgenerate
endmodule

bind qenc_position qenc_position_chk #(.CNT_W(CNT_W), .ACTIVE_LOW_EN(ACTIVE_LOW_EN)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .step_cw    (step_cw),
   .step_ccw   (step_ccw),
   .step_cw_n  (step_cw_n),
   .step_ccw_n (step_ccw_n),
   .position   (position)
);

// File: tb/qenc_position_bench.sv
module qenc_position_bench;
   localparam int W = 4;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         enc_a = 1'b0;
   logic         enc_b = 1'b0;
   logic         step_cw, step_ccw, step_cw_n, step_ccw_n;
   logic [W-1:0] position;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   string cur_req = "R9";

   // reference model state
   int hist [0:3];
   int exp_cw = 0, exp_ccw = 0, exp_pos = 0;

   always #5 clk = ~clk;

   qenc_position u_qenc_position (
      .clk(clk), .rst(rst), .enc_a(enc_a), .enc_b(enc_b),
      .step_cw(step_cw), .step_ccw(step_ccw),
      .step_cw_n(step_cw_n), .step_ccw_n(step_ccw_n),
      .position(position)
   );

   // index on the clockwise ring 00,01,11,10
   function automatic int ring(input int v);
      case (v)
         0: return 0;
         1: return 1;
         3: return 2;
         default: return 3;
      endcase
   endfunction

   // +1 clockwise, -1 anticlockwise, 0 otherwise
   function automatic int move(input int prev, input int cur);
      int d;
      d = (ring(cur) - ring(prev) + 4) % 4;
      if (d == 1) return 1;
      if (d == 3) return -1;
      return 0;
   endfunction

   always @(posedge clk) begin
      int m;
      cycles++;
      if (rst) begin
         for (int i = 0; i < 4; i++) hist[i] = 0;
         exp_cw = 0; exp_ccw = 0; exp_pos = 0;
      end else begin
         exp_pos = (exp_pos + exp_cw - exp_ccw + 16) % 16;
         for (int i = 3; i > 0; i--) hist[i] = hist[i-1];
         hist[0] = {30'd0, enc_b, enc_a};
         m = move(hist[3], hist[2]);
         exp_cw  = (m == 1) ? 1 : 0;
         exp_ccw = (m == -1) ? 1 : 0;
      end
   end

   task automatic check1(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cycles);
      end
   endtask

   task automatic compare_all();
      check1(cur_req, "step_cw", int'(step_cw), exp_cw);
      check1(cur_req, "step_ccw", int'(step_ccw), exp_ccw);
      check1(cur_req, "position", int'(position), exp_pos);
      check1("R8", "step_cw_n", int'(step_cw_n), 1 - exp_cw);
      check1("R8", "step_ccw_n", int'(step_ccw_n), 1 - exp_ccw);
      check1("R3", "both strobes", int'(step_cw & step_ccw), 0);
   endtask

   task automatic tick(input int ba);
      @(negedge clk);
      compare_all();
      enc_b = ba[1];
      enc_a = ba[0];
   endtask

   task automatic hold(input int n);
      for (int i = 0; i < n; i++) tick({30'd0, enc_b, enc_a});
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : stim
      int cwseq [4] = '{1, 3, 2, 0};
      int ccwseq [4] = '{2, 3, 1, 0};
      int fast [12] = '{1, 3, 2, 3, 1, 0, 2, 0, 1, 0, 2, 3};
      repeat (3) @(negedge clk);
      enc_b = 1'b1; enc_a = 1'b0;
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check1("R9", "reset position", int'(position), 0);
      check1("R9", "reset cw", int'(step_cw), 0);
      check1("R9", "reset ccw_n", int'(step_ccw_n), 1);
      enc_b = 1'b0; enc_a = 1'b0;
      hold(6);

      // slow clockwise, 20 steps crosses 15->0
      cur_req = "R1";
      for (int i = 0; i < 20; i++) begin
         if (i == 15) cur_req = "R7";
         tick(cwseq[i % 4]);
         hold(4);
      end
      // slow anticlockwise, 24 steps crosses 0->15
      cur_req = "R2";
      for (int i = 0; i < 24; i++) begin
         if (i == 5) cur_req = "R7";
         tick(ccwseq[i % 4]);
         hold(4);
      end

      // one step every clock with reversals
      cur_req = "R4";
      for (int r = 0; r < 3; r++)
         for (int i = 0; i < 12; i++) tick(fast[i]);
      hold(6);

      // double-bit jumps
      cur_req = "R5";
      tick(3); tick(0); hold(3);
      tick(1); tick(2); tick(1); hold(5);
      tick(3); hold(2); tick(0); hold(6);

      // long hold
      cur_req = "R6";
      hold(20);

      // reset mid-run
      cur_req = "R3";
      tick(1); tick(3);
      cur_req = "R9";
      @(negedge clk);
      compare_all();
      rst = 1'b1;
      @(negedge clk);
      check1("R9", "mid-run reset position", int'(position), 0);
      check1("R9", "mid-run reset cw", int'(step_cw), 0);
      rst = 1'b0;
      enc_b = 1'b0; enc_a = 1'b0;
      hold(8);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule